// File: doc/BRIEF.md
# Peripheral Interrupt Flag Latch

This block keeps the pending-event flag of a single peripheral and turns it into an interrupt request for the core. A one-cycle pulse (or a held level) on the event input sets the flag. The flag stays set until software clears it. The request output is the flag gated by the peripheral's local enable and by the core's global interrupt mask. A flag that cannot raise a request because of the enable or the mask stays latched, and the request appears as soon as both gates open.

Software can clear the flag in two ways. The first is a write to the status register with the flag's bit at zero. The second is a two-step access: a read or write of the status register while the flag is set arms a clear, and a later read or write of the companion data register carries it out. Either clear also throws away a request that was still waiting for its enable. An event in the same cycle as a clear keeps the flag set. A parameter can leave out the two-step clear.

Top module: `pirq_flag_latch`

## Requirements
- R1: After reset the flag is 0, `irq_o` is 0 and a status read returns all zeros.
- R2: An event (`evt_i` high at a clock edge) sets the flag at that edge. The flag never rises without an event.
- R3: `irq_o` is high in the same cycle exactly when the flag is 1, `ien_i` is 1 and `gmask_i` is 0.
- R4: While the request is blocked by `gmask_i`=1 or `ien_i`=0, the flag stays set. `irq_o` rises once both gates open.
- R5: A write to `STAT_ADDR` with bit `FLAG_BIT` of `wdata_i` at 0 clears the flag at that edge.
- R6: A write to `STAT_ADDR` with bit `FLAG_BIT` at 1 leaves the flag unchanged.
- R7: A read or write of `STAT_ADDR` while the flag is 1, followed later by a read or write of `DATA_ADDR`, clears the flag at the data access. The arming is used up by that clear.
- R8: A status access while the flag is 0 does not arm the clear. A later data access then leaves a newly set flag unchanged.
- R9: Accesses to other addresses between the two steps do not disarm the clear.
- R10: An event in the same cycle as either kind of clear leaves the flag set.
- R11: A flag cleared while the request was blocked produces no request when the gates open later.
- R12: A status read returns the flag at bit `FLAG_BIT` and zeros in all other bits. `rdata_o` is zero when no status read is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Peripheral event; sets the flag |
| ien_i | input | 1 | Local interrupt enable |
| gmask_i | input | 1 | Core global interrupt mask, 1 = masked |
| addr_i | input | ADDR_W | Register address of the current access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| irq_o | output | 1 | Interrupt request |
| rdata_o | output | DATA_W | Status readback |

## Verification
The request gate is swept over all eight combinations of flag, enable and mask, so that a wrong polarity or a missing term shows up. The two-step clear is swept over both access kinds for each step and zero to three unrelated accesses in between. This separates correct arming from arming by a single access type, and from disarming by unrelated traffic. Further patterns cover a status access with the flag clear, an event colliding with each kind of clear, and a repeat data access after a completed sequence. These show whether the arm depends on the flag, whether set wins over clear, and whether the arm is used up. Clears made while the request is masked or disabled show whether a pending request is discarded.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   typedef struct packed {
      logic stat_rd;
      logic stat_acc;
      logic data_acc;
      logic zero_wr;
   } pirq_acc_t;

   function automatic logic [31:0] bit_mask(input int unsigned pos);
      return 32'd1 << pos;
   endfunction

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned DATA_ADDR = 1,
   parameter int unsigned FLAG_BIT  = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output pirq_acc_t         acc_o
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
   localparam logic [DATA_W-1:0] F_MASK = DATA_W'(bit_mask(FLAG_BIT));

   logic hit_stat, hit_data, any_acc;

   always_comb begin
      any_acc        = rd_i | wr_i;
      hit_stat       = (addr_i == STAT_A);
      hit_data       = (addr_i == DATA_A);
      acc_o.stat_rd  = rd_i & hit_stat;
      acc_o.stat_acc = any_acc & hit_stat;
      acc_o.data_acc = any_acc & hit_data;
      acc_o.zero_wr  = wr_i & hit_stat & ((wdata_i & F_MASK) == '0);
   end
endmodule

// File: rtl/pirq_seq.sv
module pirq_seq
   import pirq_pkg::*;
#(
   parameter bit SEQ_CLR_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pirq_acc_t acc_i,
   input  logic      flag_i,
   output logic      seq_clr_o,
   output logic      armed_o
);
   if (SEQ_CLR_EN) begin : g_seq
      logic arm_q, clr_any;

      always_comb begin
         seq_clr_o = acc_i.data_acc & arm_q;
         clr_any   = seq_clr_o | acc_i.zero_wr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           arm_q <= 1'b0;
         else if (clr_any)                     arm_q <= 1'b0;
         else if (acc_i.stat_acc && flag_i)    arm_q <= 1'b1;
      end

      assign armed_o = arm_q;
   end else begin : g_noseq
      assign seq_clr_o = 1'b0;
      assign armed_o   = 1'b0;
   end
endmodule

// File: rtl/pirq_core.sv
module pirq_core
   import pirq_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              ien_i,
   input  logic              gmask_i,
   input  logic              stat_rd_i,
   input  logic              clr_i,
   output logic              flag_o,
   output logic              irq_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [DATA_W-1:0] F_MASK = DATA_W'(bit_mask(FLAG_BIT));

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= evt_i | (flag_q & ~clr_i);
   end

   always_comb begin
      flag_o  = flag_q;
      irq_o   = flag_q & ien_i & ~gmask_i;
      rdata_o = (stat_rd_i && flag_q) ? F_MASK : '0;
   end
endmodule

// File: rtl/pirq_flag_latch.sv
module pirq_flag_latch
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned STAT_ADDR  = 0,
   parameter int unsigned DATA_ADDR  = 1,
   parameter int unsigned FLAG_BIT   = 5,
   parameter bit          SEQ_CLR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              ien_i,
   input  logic              gmask_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              irq_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (FLAG_BIT >= DATA_W) begin : g_bad_bit
      $error("FLAG_BIT outside the data word");
   end
   if (STAT_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("status and data registers share an address");
   end
   if (STAT_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN) begin : g_bad_span
      $error("register address does not fit ADDR_W");
   end

   pirq_acc_t acc;
   logic      flag_w, armed_w, seq_clr, clr_all;

   pirq_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
      .DATA_ADDR(DATA_ADDR), .FLAG_BIT(FLAG_BIT)
   ) u_dec (
      .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .acc_o(acc)
   );

   pirq_seq #(.SEQ_CLR_EN(SEQ_CLR_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .flag_i(flag_w),
      .seq_clr_o(seq_clr), .armed_o(armed_w)
   );

   assign clr_all = seq_clr | acc.zero_wr;

   pirq_core #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_core (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ien_i(ien_i), .gmask_i(gmask_i),
      .stat_rd_i(acc.stat_rd), .clr_i(clr_all), .flag_o(flag_w),
      .irq_o(irq_o), .rdata_o(rdata_o)
   );
endmodule

// File: rtl/pirq_flag_latch_chk.sv
module pirq_flag_latch_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned DATA_ADDR = 1,
   parameter int unsigned FLAG_BIT  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_i,
   input logic              ien_i,
   input logic              gmask_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              rd_i,
   input logic              wr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              irq_o,
   input logic              flag_w,
   input logic              armed_w
);
   logic at_stat, at_data, acc;
   assign at_stat = (addr_i == ADDR_W'(STAT_ADDR));
   assign at_data = (addr_i == ADDR_W'(DATA_ADDR));
   assign acc     = rd_i | wr_i;

   // R2
   set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_w);
   // R2
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_w && !evt_i) |=> !flag_w);
   // R3
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag_w && ien_i && !gmask_i));
   // R4
   hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_w && !(acc && (at_stat || at_data))) |=> flag_w);
   // R5
   zero_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && at_stat && !wdata_i[FLAG_BIT] && !evt_i) |=> !flag_w);
   // R6
   one_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && at_stat && wdata_i[FLAG_BIT] && flag_w) |=> flag_w);
   // R7
   arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_w |-> flag_w);
   // R7
   seq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_w && acc && at_data && !evt_i) |=> !flag_w);
endmodule

bind pirq_flag_latch pirq_flag_latch_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
   .DATA_ADDR(DATA_ADDR), .FLAG_BIT(FLAG_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ien_i(ien_i), .gmask_i(gmask_i),
   .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
   .irq_o(irq_o), .flag_w(flag_w), .armed_w(armed_w)
);

// File: tb/pirq_flag_latch_tb_top.sv
module pirq_flag_latch_tb_top;
   localparam int AW = 4, DW = 8, SA = 0, DA = 1, FB = 5;
   localparam logic [DW-1:0] FMASK = DW'(1) << FB;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt = 0, ien = 0, gm = 0, rd = 0, wr = 0;
   logic [AW-1:0] addr = 4'd3;
   logic [DW-1:0] wdata = '0;
   logic irq;
   logic [DW-1:0] rdata;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   pirq_flag_latch #(.ADDR_W(AW), .DATA_W(DW), .STAT_ADDR(SA), .DATA_ADDR(DA),
      .FLAG_BIT(FB), .SEQ_CLR_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ien_i(ien), .gmask_i(gm),
      .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
      .irq_o(irq), .rdata_o(rdata));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      evt = 0; rd = 0; wr = 0; addr = 4'd3; wdata = '0;
   endtask

   // Observes the flag through the request output with both gates opened.
   task automatic flag_now(output logic f);
      logic si, sg;
      si = ien; sg = gm;
      ien = 1; gm = 0; #1; f = irq;
      ien = si; gm = sg; #1;
   endtask

   task automatic acc(input int a, input bit isw, input logic [DW-1:0] wd, input bit e);
      addr = AW'(a); rd = !isw; wr = isw; wdata = wd; evt = e;
      tick(); idle();
   endtask

   task automatic pulse();
      evt = 1; tick(); evt = 0;
   endtask

   task automatic chk_flag(input string req, input logic exp);
      logic f;
      flag_now(f);
      chk(req, DW'(f), DW'(exp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state seen at the ports
      ien = 1; gm = 0; #1; chk("R1 irq", DW'(irq), '0);
      addr = AW'(SA); rd = 1; #1; chk("R1 rdata", rdata, '0); idle(); #1;
      rst_n = 1; tick();
      chk_flag("R1 flag", 0);

      // R3: request gate sweep over flag, enable and mask
      for (int f = 0; f < 2; f++) begin
         if (f == 1) begin pulse(); chk_flag("R2 set", 1); end
         for (int c = 0; c < 4; c++) begin
            ien = c[0]; gm = c[1]; #1;
            chk("R3 gate", DW'(irq), DW'(f & c[0] & ~c[1]));
         end
      end

      // R12: readback with flag set, then R5 zero write, readback clear
      addr = AW'(SA); rd = 1; #1; chk("R12 set", rdata, FMASK); tick(); idle(); #1;
      chk("R12 idle", rdata, '0);
      acc(SA, 1, ~FMASK, 0); chk_flag("R5 clear", 0);
      addr = AW'(SA); rd = 1; #1; chk("R12 clr", rdata, '0); tick(); idle();

      // R6: writing one keeps the flag (and arms); R7 data read then clears
      pulse();
      acc(SA, 1, '1, 0); chk_flag("R6 keep", 1);
      acc(DA, 0, '0, 0); chk_flag("R7 clear", 0);

      // R7 and R9: sweep access kinds and intervening traffic
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++) begin
               pulse();
               acc(SA, s[0], FMASK, 0);
               for (int j = 0; j < k; j++) acc(2 + j % 2, j[0], '0, 0);
               chk_flag("R9 armed holds", 1);
               acc(DA, d[0], '0, 0);
               chk_flag("R7 seq clear", 0);
            end

      // R8: status access with flag clear does not arm
      acc(SA, 0, '0, 0);
      pulse();
      acc(DA, 0, '0, 0); chk_flag("R8 no arm", 1);
      acc(DA, 1, '0, 0); chk_flag("R8 no arm wr", 1);
      acc(SA, 1, '0, 0); chk_flag("R5 clear2", 0);

      // R10: event collides with each clear
      pulse();
      acc(SA, 1, '0, 1); chk_flag("R10 zero wr", 1);
      acc(SA, 0, '0, 0);
      acc(DA, 0, '0, 1); chk_flag("R10 seq", 1);
      // R7: arming used up by the sequence
      acc(DA, 0, '0, 0); chk_flag("R7 used up", 1);
      acc(SA, 1, '0, 0); chk_flag("R5 clear3", 0);

      // R4: pending while masked or disabled
      ien = 1; gm = 1; pulse(); #1; chk("R4 masked", DW'(irq), '0);
      repeat (3) tick();
      gm = 0; #1; chk("R4 unmask", DW'(irq), 1);
      ien = 0; repeat (3) tick(); chk("R4 disabled", DW'(irq), '0);
      ien = 1; #1; chk("R4 enable", DW'(irq), 1);

      // R11: clears while blocked discard the request
      gm = 1; acc(SA, 1, '0, 0); gm = 0; #1; chk("R11 zero wr", DW'(irq), '0);
      ien = 0; pulse();
      acc(SA, 0, '0, 0); acc(DA, 1, '0, 0);
      ien = 1; #1; chk("R11 seq", DW'(irq), '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule